// File: doc/BRIEF.md
# Infrared Receive Interval Capture

This block times an incoming infrared receive signal. After it has been enabled for receive, the first qualified edge on the pin starts a 16-bit up-counter from zero. The counter advances either once per IR clock (here one system clock per step) or once per carrier period, where the carrier period comes from programmable high and low counts. On every later qualified edge the block stores the counter value and the direction of the edge, raises a one-cycle interval flag, and either clears the counter or lets it run on.

A burst-count mode serves IR learning. When it is switched on, the capture register is preset to one. From then on each qualified edge adds one to it and no time value is stored. If two carrier periods pass with no qualified edge, the carrier is taken to be absent. The interval flag then marks the start of a space, and software reads the number of edges in the burst that has just ended. The pin is first passed through a two-flop synchronizer.

A four-state machine controls the block. OFF holds while receive is not active. OFF→ARM is taken once receive becomes active. ARM→RUN is taken on the first qualified edge. RUN→GAP is the burst-mode carrier timeout. GAP→RUN is taken on the next qualified edge. Leaving receive sends any state back to OFF.

Top module: `ir_rx_capture`

## Requirements
- R1: After reset, cap_value is 0000h, cap_level is 0, and interval_flag, overflow_flag and irq are 0.
- R2: Receive is active only while rx_enable=1 and tx_mode=0. While receive is inactive, no flag or interrupt is produced, cap_value and cap_level hold, and the counter is cleared.
- R3: In normal mode (burst_en=0), the first qualified edge after activation only starts the counter at 0000h. Each later qualified edge copies the counter into cap_value, sets cap_level to 1 for a rising edge or 0 for a falling edge, and pulses interval_flag for one cycle. This happens two clocks after the synchronized pin changes.
- R4: edge_sel selects the qualified edges: 2'b00 none, 2'b01 falling only, 2'b10 rising only, 2'b11 both. A change that is not qualified has no effect on cap_value or the flags.
- R5: With reload_en=1, a qualified edge clears the counter to 0000h, so cap_value is the edge spacing minus one tick. With reload_en=0, the counter runs on, so cap_value is the time since the first edge minus one tick.
- R6: With clk_sel=1, the counter advances once per clock. With clk_sel=0, it advances once per carrier period of car_high+car_low+2 clocks, and the carrier phase restarts at every qualified edge. A spacing of N clocks therefore captures floor((N-1)/P).
- R7: When the counter steps from FFFFh to 0000h, overflow_flag pulses for one cycle and counting continues.
- R8: A 0→1 change of burst_en while receive is active loads cap_value with 0001h. While burst_en=1, every qualified edge, including the first, adds one to cap_value, and cap_level does not change.
- R9: While burst_en=1, interval_flag pulses once when two carrier periods pass after a qualified edge with no further qualified edge. Every qualified edge restarts this timeout.
- R10: irq pulses in the same cycle as interval_flag or overflow_flag when irq_en=1, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the IR clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_pin | input | 1 | Asynchronous IR receive pin (idle high) |
| rx_enable | input | 1 | Timer enable |
| tx_mode | input | 1 | 1 = transmit mode (receive inactive) |
| edge_sel | input | 2 | Qualified edge select |
| reload_en | input | 1 | Clear counter on each qualified edge |
| clk_sel | input | 1 | 1 = count clocks, 0 = count carrier periods |
| car_high | input | 8 | Carrier high count (high time = value+1) |
| car_low | input | 8 | Carrier low count (low time = value+1) |
| burst_en | input | 1 | Burst-count mode |
| irq_en | input | 1 | Interrupt enable |
| cap_value | output | 16 | Captured count or burst edge count |
| cap_level | output | 1 | Pin level after the last captured edge |
| interval_flag | output | 1 | One-cycle capture or space-start pulse |
| overflow_flag | output | 1 | One-cycle counter wrap pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions check on every cycle that an inactive receive leaves the flags quiet and the capture state frozen. They also check that the interrupt follows the flags and the enable exactly, that a burst-mode start loads one, and that cap_level stays fixed in burst mode. The actual captured values can only be shown by the bench scenarios. These cover edge spacings in clocks and in carrier periods of two lengths, the reload and run-on cases, every edge-select code, a full counter wrap, and the burst counts with the timeout both firing and being restarted by edges six clocks apart.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2,
        ST_GAP = 2'd3
    } rx_state_t;
endpackage

// File: rtl/ir_rx_edge_detect.sv
module ir_rx_edge_detect #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int SH_W = STAGES + 1;
    logic [SH_W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= {SH_W{IDLE_LVL}};
        else        sh <= {sh[SH_W-2:0], pin};
    end

    // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
    assign rise =  sh[STAGES-1] & ~sh[STAGES];
    assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/ir_carrier_div.sv
module ir_carrier_div #(
    parameter int CAR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [CAR_W-1:0] car_high,
    input  logic [CAR_W-1:0] car_low,
    output logic             tick
);
    localparam int DIV_W = CAR_W + 1;
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] last;

    // period = high + low + 2 clocks; the tick marks the final clock of a period
    assign last = DIV_W'(car_high) + DIV_W'(car_low) + DIV_W'(1);
    assign tick = (div == last) & ~clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div <= '0;
        else if (clear || tick) div <= '0;
        else                    div <= div + DIV_W'(1);
    end
endmodule

// File: rtl/ir_rx_capture.sv
module ir_rx_capture
    import ir_rx_pkg::*;
#(
    parameter int   CNT_W       = 16,
    parameter int   CAR_W       = 8,
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LVL    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pin,
    input  logic             rx_enable,
    input  logic             tx_mode,
    input  logic [1:0]       edge_sel,
    input  logic             reload_en,
    input  logic             clk_sel,
    input  logic [CAR_W-1:0] car_high,
    input  logic [CAR_W-1:0] car_low,
    input  logic             burst_en,
    input  logic             irq_en,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_level,
    output logic             interval_flag,
    output logic             overflow_flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    rx_state_t        state, state_nxt;
    logic             rx_active;
    logic             edge_rise, edge_fall, edge_q;
    logic             car_tick, cnt_tick;
    logic             counting;
    logic             burst_q, burst_rise;
    logic             gap_cnt;
    logic             gap_done, capture, wrap;
    logic [CNT_W-1:0] cnt;

    ir_rx_edge_detect #(
        .STAGES  (SYNC_STAGES),
        .IDLE_LVL(IDLE_LVL)
    ) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (rx_pin),
        .rise (edge_rise),
        .fall (edge_fall)
    );

    ir_carrier_div #(
        .CAR_W(CAR_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (edge_q | ~rx_active),
        .car_high(car_high),
        .car_low (car_low),
        .tick    (car_tick)
    );

    assign rx_active  = rx_enable & ~tx_mode;
    assign edge_q     = (edge_sel[1] & edge_rise) | (edge_sel[0] & edge_fall);
    assign cnt_tick   = clk_sel ? 1'b1 : car_tick;
    assign counting   = (state == ST_RUN) || (state == ST_GAP);
    assign burst_rise = burst_en & ~burst_q;
    assign capture    = rx_active & counting & edge_q & ~burst_en;
    assign wrap       = rx_active & counting & cnt_tick & (cnt == CNT_MAX)
                        & ~(edge_q & reload_en);
    assign gap_done   = rx_active & burst_en & (state == ST_RUN) & car_tick
                        & gap_cnt & ~edge_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    // next state
    always_comb begin
        state_nxt = state;
        if (!rx_active) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF: state_nxt = ST_ARM;
                ST_ARM: state_nxt = edge_q ? ST_RUN : ST_ARM;
                ST_RUN: state_nxt = gap_done ? ST_GAP : ST_RUN;
                ST_GAP: state_nxt = edge_q ? ST_RUN : ST_GAP;
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_value     <= '0;
            cap_level     <= 1'b0;
            interval_flag <= 1'b0;
            overflow_flag <= 1'b0;
            irq           <= 1'b0;
            cnt           <= '0;
            gap_cnt       <= 1'b0;
            burst_q       <= 1'b0;
        end else begin
            burst_q       <= burst_en;
            interval_flag <= capture | gap_done;
            overflow_flag <= wrap;
            irq           <= irq_en & (capture | gap_done | wrap);
            if (!rx_active) begin
                cnt     <= '0;
                gap_cnt <= 1'b0;
            end else begin
                if (burst_rise) begin
                    cap_value <= CNT_ONE;
                end else if (burst_en && edge_q && state != ST_OFF) begin
                    cap_value <= cap_value + CNT_ONE;
                end else if (capture) begin
                    cap_value <= cnt;
                    cap_level <= edge_rise;
                end

                unique case (state)
                    ST_OFF, ST_ARM: cnt <= '0;
                    default: cnt <= (edge_q && reload_en) ? '0
                                    : cnt + CNT_W'(cnt_tick);
                endcase

                if (edge_q || state != ST_RUN || !burst_en) gap_cnt <= 1'b0;
                else if (car_tick)                          gap_cnt <= ~gap_cnt;
            end
        end
    end
endmodule

// File: rtl/ir_rx_capture_chk.sv
module ir_rx_capture_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_enable,
    input logic             tx_mode,
    input logic             burst_en,
    input logic             irq_en,
    input logic [CNT_W-1:0] cap_value,
    input logic             cap_level,
    input logic             interval_flag,
    input logic             overflow_flag,
    input logic             irq
);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_enable && !tx_mode) |=> !interval_flag && !overflow_flag
                                     && $stable(cap_value) && $stable(cap_level));

    a_r8_burst_load: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_en) && rx_enable && !tx_mode |=> cap_value == CNT_W'(1));

    a_r8_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        burst_en |=> $stable(cap_level));

    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> interval_flag || overflow_flag);

    a_r10_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_flag || overflow_flag) && $past(irq_en) |-> irq);

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(irq_en) |-> !irq);

    a_r7_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_flag |=> !overflow_flag);
endmodule

bind ir_rx_capture ir_rx_capture_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_enable    (rx_enable),
    .tx_mode      (tx_mode),
    .burst_en     (burst_en),
    .irq_en       (irq_en),
    .cap_value    (cap_value),
    .cap_level    (cap_level),
    .interval_flag(interval_flag),
    .overflow_flag(overflow_flag),
    .irq          (irq)
);

// File: tb/ir_rx_capture_test.sv
module ir_rx_capture_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_pin = 1'b1;
    logic        rx_enable = 1'b0;
    logic        tx_mode = 1'b0;
    logic [1:0]  edge_sel = 2'b11;
    logic        reload_en = 1'b1;
    logic        clk_sel = 1'b1;
    logic [7:0]  car_high = 8'd1;
    logic [7:0]  car_low = 8'd1;
    logic        burst_en = 1'b0;
    logic        irq_en = 1'b1;
    logic [15:0] cap_value;
    logic        cap_level;
    logic        interval_flag;
    logic        overflow_flag;
    logic        irq;

    always #5 clk = ~clk;

    ir_rx_capture uut (
        .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_enable(rx_enable),
        .tx_mode(tx_mode), .edge_sel(edge_sel), .reload_en(reload_en),
        .clk_sel(clk_sel), .car_high(car_high), .car_low(car_low),
        .burst_en(burst_en), .irq_en(irq_en), .cap_value(cap_value),
        .cap_level(cap_level), .interval_flag(interval_flag),
        .overflow_flag(overflow_flag), .irq(irq)
    );

    typedef struct {
        logic [15:0] v;
        logic        l;
        string       req;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_chk = 0, n_fail = 0;
    int   n_flags = 0, n_ovf = 0, n_irq = 0;
    bit   done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (interval_flag) begin
                n_flags++;
                if (q.size() == 0) begin
                    check(1'b0, "R3", "unexpected interval_flag", 1, 0);
                end else begin
                    e = q.pop_front();
                    check(cap_value == e.v, e.req, "cap_value", cap_value, e.v);
                    check(cap_level == e.l, e.req, "cap_level", cap_level, e.l);
                end
            end
            if (overflow_flag) n_ovf++;
            if (irq) n_irq++;
            if (irq && !(interval_flag || overflow_flag))
                check(1'b0, "R10", "irq without flag", 1, 0);
        end
    end

    task automatic drive(input logic lvl, input int n);
        @(negedge clk);
        rx_pin = lvl;
        repeat (n - 1) @(negedge clk);
    endtask

    // driver: queues the expected capture, then drives the edge
    task automatic drive_e(input logic lvl, input int n, input int v,
                           input logic l, input string req);
        exp_t x;
        x.v = 16'(v); x.l = l; x.req = req;
        q.push_back(x);
        drive(lvl, n);
    endtask

    task automatic expect_item(input int v, input logic l, input string req);
        exp_t x;
        x.v = 16'(v); x.l = l; x.req = req;
        q.push_back(x);
    endtask

    task automatic cfg(input logic [1:0] sel, input logic rl, input logic cs,
                       input logic [7:0] h, input logic [7:0] l, input logic ie);
        @(negedge clk);
        rx_enable = 1'b0;
        repeat (2) @(negedge clk);
        edge_sel = sel; reload_en = rl; clk_sel = cs;
        car_high = h; car_low = l; irq_en = ie; tx_mode = 1'b0;
        rx_enable = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic settle(input int n, input string req);
        repeat (n) @(negedge clk);
        #1;
        check(q.size() == 0, req, "pending expected captures", q.size(), 0);
    endtask

    initial begin
        int nf, ov0, i0;
        logic [15:0] cv;
        logic lv;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(cap_value == 16'h0, "R1", "cap_value", cap_value, 0);
        check(cap_level == 1'b0, "R1", "cap_level", cap_level, 0);
        check(interval_flag == 1'b0 && overflow_flag == 1'b0, "R1", "flags", interval_flag, 0);
        check(irq == 1'b0, "R1", "irq", irq, 0);

        // R3 / R6: both edges, reload, clock counting
        cfg(2'b11, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        drive(1'b0, 20);
        drive_e(1'b1, 35, 19, 1'b1, "R3");
        drive_e(1'b0, 50, 34, 1'b0, "R3");
        drive_e(1'b1, 10, 49, 1'b1, "R3");
        settle(10, "R3");

        // R4: falling edges only
        cfg(2'b01, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        drive(1'b0, 10);
        drive(1'b1, 15);
        drive_e(1'b0, 20, 24, 1'b0, "R4");
        drive(1'b1, 5);
        drive_e(1'b0, 10, 24, 1'b0, "R4");
        settle(10, "R4");

        // R4: rising edges only
        cfg(2'b10, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        drive(1'b1, 8);
        drive(1'b0, 12);
        drive_e(1'b1, 6, 19, 1'b1, "R4");
        settle(10, "R4");

        // R4: no edges qualified
        cfg(2'b00, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        #1; nf = n_flags; cv = cap_value;
        drive(1'b0, 10); drive(1'b1, 10); drive(1'b0, 10); drive(1'b1, 10);
        repeat (5) @(negedge clk); #1;
        check(n_flags == nf, "R4", "flags with edge_sel 00", n_flags, nf);
        check(cap_value == cv, "R4", "cap_value with edge_sel 00", cap_value, cv);

        // R5: counter runs on without reload
        cfg(2'b11, 1'b0, 1'b1, 8'd1, 8'd1, 1'b1);
        drive(1'b0, 10);
        drive_e(1'b1, 20, 9, 1'b1, "R5");
        drive_e(1'b0, 30, 29, 1'b0, "R5");
        drive_e(1'b1, 5, 59, 1'b1, "R5");
        settle(10, "R5");

        // R6: carrier counting, period 4 then period 5
        cfg(2'b11, 1'b1, 1'b0, 8'd1, 8'd1, 1'b1);
        drive(1'b0, 40);
        drive_e(1'b1, 41, 9, 1'b1, "R6");
        drive_e(1'b0, 12, 10, 1'b0, "R6");
        drive_e(1'b1, 5, 2, 1'b1, "R6");
        settle(10, "R6");
        cfg(2'b11, 1'b1, 1'b0, 8'd3, 8'd0, 1'b1);
        drive(1'b0, 23);
        drive_e(1'b1, 5, 4, 1'b1, "R6");
        settle(10, "R6");

        // R7: counter wrap
        cfg(2'b11, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        #1; ov0 = n_ovf;
        drive(1'b0, 65600);
        drive_e(1'b1, 10, 63, 1'b1, "R7");
        settle(10, "R7");
        check(n_ovf == ov0 + 1, "R7", "overflow pulses", n_ovf, ov0 + 1);
        check(n_irq == n_flags + n_ovf, "R10", "irq pulses with irq_en=1",
              n_irq, n_flags + n_ovf);

        // R10: interrupt masked
        cfg(2'b11, 1'b1, 1'b1, 8'd1, 8'd1, 1'b0);
        #1; i0 = n_irq;
        drive(1'b0, 10);
        drive_e(1'b1, 10, 9, 1'b1, "R10");
        drive_e(1'b0, 10, 9, 1'b0, "R10");
        settle(10, "R10");
        check(n_irq == i0, "R10", "irq with irq_en=0", n_irq, i0);

        // R2: transmit mode ignores the pin
        cfg(2'b11, 1'b1, 1'b1, 8'd1, 8'd1, 1'b1);
        @(negedge clk); tx_mode = 1'b1;
        #1; nf = n_flags; cv = cap_value; lv = cap_level; ov0 = n_ovf;
        drive(1'b1, 10); drive(1'b0, 10); drive(1'b1, 10);
        repeat (5) @(negedge clk); #1;
        check(n_flags == nf, "R2", "flags in transmit mode", n_flags, nf);
        check(cap_value == cv && cap_level == lv, "R2", "capture state in transmit mode",
              cap_value, cv);
        check(n_ovf == ov0, "R2", "overflow in transmit mode", n_ovf, ov0);
        tx_mode = 1'b0;

        // R8 / R9: burst counting and space detection, period 4
        cfg(2'b11, 1'b1, 1'b0, 8'd1, 8'd1, 1'b1);
        @(negedge clk); burst_en = 1'b1;
        repeat (2) @(negedge clk); #1;
        check(cap_value == 16'd1, "R8", "cap_value after burst start", cap_value, 1);
        drive(1'b0, 3); drive(1'b1, 3); drive(1'b0, 3); drive(1'b1, 3); drive(1'b0, 3);
        expect_item(6, 1'b0, "R9");
        settle(20, "R9");
        check(cap_value == 16'd6, "R8", "burst edge count", cap_value, 6);
        drive(1'b1, 6); drive(1'b0, 6); drive(1'b1, 6);
        expect_item(9, 1'b0, "R9");
        settle(20, "R9");
        @(negedge clk); burst_en = 1'b0;
        repeat (2) @(negedge clk); burst_en = 1'b1;
        repeat (2) @(negedge clk); #1;
        check(cap_value == 16'd1, "R8", "cap_value after burst restart", cap_value, 1);
        burst_en = 1'b0;
        rx_enable = 1'b0;
        settle(5, "R3");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R3 run did not complete actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule